// File: doc/BRIEF.md
# SPI Byte-Stream Transfer Engine

This block is a SPI master that runs one framed transaction for each start pulse. A transaction holds chip select low for its whole length. It first sends a programmed number of outgoing bytes and then clocks in a programmed number of incoming bytes. Both counts are sampled when the start pulse is taken. Outgoing bytes are not preloaded. Before each one the engine raises a request, then waits with the serial clock parked low until a supplier returns the byte with a one-cycle enable pulse. Each incoming byte appears on a parallel output together with a one-cycle valid pulse.

The serial clock runs in mode 0. It idles low, data out changes after a falling edge, and data in is sampled on the rising edge, most significant bit first. An input divisor sets how many system clock cycles make up each half period of the serial clock. Chip select leads the first edge, trails the last edge, and stays high between frames, each for at least one half period. An idle flag shows when the engine can accept a new start.

Top module: `spi_stream_engine`

## Requirements
- R1: Each high phase of `sclk` lasts exactly `half_div` clock cycles, and a `half_div` of 0 behaves as 1.
- R2: A `start` pulse taken while `idle` is high, with at least one non-zero count, drives `idle` and `cs_n` low on the next cycle.
- R3: `sclk` stays low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. All transmit bytes go out before any receive byte, each most significant bit first.
- R4: Before each transmit byte, `tx_req` rises and holds high until `tx_valid` is seen. `sclk` does not toggle while `tx_req` is high, and the byte on `tx_byte` in the `tx_valid` cycle is the one sent next.
- R5: After the transmit bytes, exactly `rx_count` bytes are sampled from `miso` on rising `sclk` edges, most significant bit first. Each byte is presented on `rx_byte` with a `rx_valid` pulse that lasts one cycle.
- R6: During the receive phase, `mosi` is held low, so every receive-phase byte seen by the device is 0x00.
- R7: `cs_n` falls at least one half period before the first rising `sclk` edge and rises at least one half period after the last falling edge. It then stays high for at least one half period before the next fall.
- R8: `idle` rises only after `cs_n` has returned high and a further half period has passed. `cs_n` is high whenever `idle` is high.
- R9: A `start` with both counts zero leaves `cs_n` high and `idle` high, and no clock edge is produced.
- R10: A `start` pulse while `idle` is low is ignored. The running transaction keeps its own counts.
- R11: While `rst` is high, the engine returns at the next clock edge to `idle` high, `cs_n` high, `sclk` low, `tx_req` low and `rx_valid` low, even in the middle of a transaction.
- R12: Counts use the full 12-bit range, so a transaction with more than 255 receive bytes delivers all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | 8 | System clock cycles per serial clock half period (0 acts as 1) |
| start | input | 1 | One-cycle pulse that begins a transaction |
| tx_count | input | 12 | Number of bytes to transmit, sampled at start |
| rx_count | input | 12 | Number of bytes to receive, sampled at start |
| tx_req | output | 1 | High while the engine waits for the next transmit byte |
| tx_byte | input | 8 | Transmit byte supplied in the tx_valid cycle |
| tx_valid | input | 1 | One-cycle pulse that hands over tx_byte |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse marking a new rx_byte |
| idle | output | 1 | High when no transaction is in progress |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the engine with its default parameters: an 8-bit divisor and 12-bit byte counts. It then varies the divisor at run time through 0, 1, 2 and 3, which covers the treatment of 0 as 1 and the shortest possible half period. The 12-bit count width lets one run carry 300 receive bytes, which passes the 8-bit boundary of the byte counter. A device model on the serial lines returns a known byte sequence. Each transaction is paired with back-to-back frames, a start issued while busy, and a reset in mid-frame, so the framing gaps and the handshake are tested across both phases.

// File: rtl/spi_stream_pkg.sv
package spi_stream_pkg;

    // Bits per serial byte.
    localparam int BYTE_BITS = 8;

    // Engine sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_LEAD,   // chip select low, before first edge
        ST_REQ,    // waiting on the byte supplier
        ST_SHIFT,  // clocking one byte
        ST_TRAIL,  // after last edge, chip select still low
        ST_GAP     // chip select high, minimum deselect time
    } eng_state_t;

    // Next state once a byte has fully shifted.
    function automatic eng_state_t after_byte(input logic tx_more, input logic rx_more);
        if (tx_more)
            return ST_REQ;
        else if (rx_more)
            return ST_SHIFT;
        return ST_TRAIL;
    endfunction

endpackage

// File: rtl/spi_stream_tick.sv
module spi_stream_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    // A zero divisor is treated as one cycle per half period.
    assign limit = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick  = run && (cnt == limit - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/spi_stream_shift.sv
module spi_stream_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         rise,
    input  logic         fall,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_sh;
    logic [W-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst)
            tx_sh <= '0;
        else if (load)
            tx_sh <= load_val;
        else if (fall)
            tx_sh <= {tx_sh[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_sh <= '0;
        else if (rise)
            rx_sh <= {rx_sh[W-2:0], miso};
    end

    assign mosi    = tx_sh[W-1];
    assign rx_word = rx_sh;
endmodule

// File: rtl/spi_stream_engine.sv
module spi_stream_engine
    import spi_stream_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     half_div,
    input  logic                 start,
    input  logic [CNT_W-1:0]     tx_count,
    input  logic [CNT_W-1:0]     rx_count,
    output logic                 tx_req,
    input  logic [BYTE_BITS-1:0] tx_byte,
    input  logic                 tx_valid,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 idle,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int BW    = BYTE_BITS;
    localparam int IDX_W = $clog2(BW);

    eng_state_t      state;
    logic [CNT_W-1:0] tx_left, rx_left;
    logic [IDX_W-1:0] bit_cnt;
    logic            sclk_r, cs_n_r, idle_r, cur_rx, rx_valid_r;
    logic [BW-1:0]   rx_byte_r, load_val, rx_word;
    logic            run, tick, rise, fall, last_fall, load, begin_rx;

    assign run = (state == ST_LEAD) || (state == ST_SHIFT) ||
                 (state == ST_TRAIL) || (state == ST_GAP);

    spi_stream_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    assign rise      = tick && (state == ST_SHIFT) && !sclk_r;
    assign fall      = tick && (state == ST_SHIFT) && sclk_r;
    assign last_fall = fall && (bit_cnt == IDX_W'(BW - 1));

    // A receive byte starts once the transmit bytes are used up.
    always_comb begin
        begin_rx = 1'b0;
        if ((state == ST_LEAD && tick) || last_fall)
            begin_rx = (tx_left == '0) && (rx_left != '0);
    end

    assign load     = begin_rx || (state == ST_REQ && tx_valid);
    assign load_val = (state == ST_REQ) ? tx_byte : '0;

    spi_stream_shift #(.W(BW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .rise     (rise),
        .fall     (fall),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            sclk_r     <= 1'b0;
            cs_n_r     <= 1'b1;
            idle_r     <= 1'b1;
            tx_left    <= '0;
            rx_left    <= '0;
            bit_cnt    <= '0;
            cur_rx     <= 1'b0;
            rx_valid_r <= 1'b0;
            rx_byte_r  <= '0;
        end else begin
            rx_valid_r <= 1'b0;
            if (rise)
                sclk_r <= 1'b1;
            if (fall) begin
                sclk_r  <= 1'b0;
                bit_cnt <= bit_cnt + IDX_W'(1);
            end
            if (last_fall && cur_rx) begin
                rx_valid_r <= 1'b1;
                rx_byte_r  <= rx_word;
            end
            if (begin_rx) begin
                rx_left <= rx_left - CNT_W'(1);
                cur_rx  <= 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start && (tx_count != '0 || rx_count != '0)) begin
                        tx_left <= tx_count;
                        rx_left <= rx_count;
                        cs_n_r  <= 1'b0;
                        idle_r  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick)
                        state <= (tx_left != '0) ? ST_REQ : ST_SHIFT;
                end
                ST_REQ: begin
                    if (tx_valid) begin
                        tx_left <= tx_left - CNT_W'(1);
                        cur_rx  <= 1'b0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (last_fall)
                        state <= after_byte(tx_left != '0, rx_left != '0);
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n_r <= 1'b1;
                        state  <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        idle_r <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_req   = (state == ST_REQ);
    assign rx_byte  = rx_byte_r;
    assign rx_valid = rx_valid_r;
    assign idle     = idle_r;
    assign sclk     = sclk_r;
    assign cs_n     = cs_n_r;
endmodule

// File: rtl/spi_stream_engine_chk.sv
module spi_stream_engine_chk (
    input logic clk,
    input logic rst,
    input logic idle,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic tx_req,
    input logic tx_valid,
    input logic rx_valid
);
    // R8
    cs_high_idle_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> cs_n);

    // R3
    sclk_parked_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_valid) |=> tx_req);

    // R4
    req_noclk_chk: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> !sclk);

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind spi_stream_engine spi_stream_engine_chk u_spi_stream_engine_chk (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .tx_req   (tx_req),
    .tx_valid (tx_valid),
    .rx_valid (rx_valid)
);

// File: tb/spi_stream_engine_bench.sv
module spi_stream_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  half_div = 8'd2;
    logic        start = 1'b0;
    logic [11:0] tx_count = '0;
    logic [11:0] rx_count = '0;
    logic        tx_req;
    logic [7:0]  tx_byte = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        idle, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int eff_div = 2;
    bit mon_off = 1'b0;

    logic [7:0] src_q[$];
    logic [7:0] exp_mosi[$];
    logic [7:0] exp_rx[$];
    int cur_ntx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_stream_engine u_spi_stream_engine (
        .clk(clk), .rst(rst), .half_div(half_div), .start(start),
        .tx_count(tx_count), .rx_count(rx_count), .tx_req(tx_req),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .idle(idle), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] resp(input int n);
        return 8'(8'h3C + n * 29);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Device model: mode 0, MSB first, known reply sequence.
    logic [7:0] s_in, s_out;
    int  s_bit, s_byte;
    logic p_cs = 1'b1, p_sclk = 1'b0;
    always @(cs_n or sclk) begin
        if (p_cs && !cs_n) begin
            s_bit = 0; s_byte = 0; s_out = resp(0); miso = s_out[7];
        end else if (!cs_n && !p_sclk && sclk) begin
            s_in = {s_in[6:0], mosi}; s_bit++;
        end else if (!cs_n && p_sclk && !sclk) begin
            if (s_bit == 8) begin
                if (!mon_off) begin
                    if (exp_mosi.size() == 0)
                        chk(0, "R3", "unexpected serial byte", s_in, -1);
                    else if (s_byte < cur_ntx)
                        // R3 transmit bytes in order, MSB first
                        chk(s_in == exp_mosi[0], "R3", "mosi byte", s_in, exp_mosi[0]);
                    else
                        // R6 receive phase drives zeros
                        chk(s_in == exp_mosi[0], "R6", "mosi in rx phase", s_in, exp_mosi[0]);
                    if (exp_mosi.size() != 0) void'(exp_mosi.pop_front());
                end
                s_byte++; s_bit = 0; s_out = resp(s_byte);
            end else begin
                s_out = s_out << 1;
            end
            miso = s_out[7];
        end
        p_cs = cs_n; p_sclk = sclk;
    end

    // Byte supplier: answers each request two cycles later.
    always begin
        @(negedge clk);
        if (tx_req && !rst) begin
            repeat (2) @(negedge clk);
            // R4 request held, clock parked
            chk(tx_req === 1'b1 && sclk === 1'b0, "R4", "req held/sclk low", {tx_req, sclk}, 2);
            tx_byte  = (src_q.size() != 0) ? src_q.pop_front() : 8'h00;
            tx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
        end
    end

    // Receive scoreboard monitor.
    always @(negedge clk) begin
        if (rx_valid && !mon_off) begin
            if (exp_rx.size() == 0)
                chk(0, "R5", "unexpected rx byte", rx_byte, -1);
            else
                // R5 received byte order and value
                chk(rx_byte == exp_rx.pop_front(), "R5", "rx byte", rx_byte, -1);
        end
    end

    // Timing monitor: half period, lead, trail, gap.
    int hi = 0, lead = 0, trail = 0, gap = 0;
    bit seen_rise = 0, seen_low = 0;
    logic m_cs = 1'b1;
    always @(negedge clk) begin
        if (rst || mon_off) begin
            hi = 0; lead = 0; trail = 0; gap = 0; seen_rise = 0;
        end else begin
            if (sclk) hi++;
            else if (hi != 0) begin
                // R1 high phase width
                chk(hi == eff_div, "R1", "sclk high cycles", hi, eff_div);
                hi = 0;
            end
            if (!cs_n) begin
                if (!m_cs == 1'b0 && gap > 0 && seen_low)
                    // R7 deselect gap
                    chk(gap >= eff_div, "R7", "cs high gap", gap, eff_div);
                gap = 0;
                seen_low = 1;
                if (!seen_rise && !sclk) lead++;
                if (!seen_rise && sclk) begin
                    // R7 lead time
                    chk(lead >= eff_div, "R7", "cs lead", lead, eff_div);
                    seen_rise = 1;
                end
                if (sclk) trail = 0; else trail++;
            end else begin
                if (!m_cs && seen_rise)
                    // R7 trail time
                    chk(trail >= eff_div, "R7", "cs trail", trail, eff_div);
                lead = 0; trail = 0; seen_rise = 0;
                gap++;
            end
        end
        m_cs = cs_n;
    end

    task automatic launch(input int ntx, input int nrx, input int seed);
        cur_ntx = ntx;
        for (int i = 0; i < ntx; i++) begin
            logic [7:0] b = 8'(seed * 7 + i * 13 + 1);
            src_q.push_back(b);
            exp_mosi.push_back(b);
        end
        for (int j = 0; j < nrx; j++) begin
            exp_mosi.push_back(8'h00);
            exp_rx.push_back(resp(ntx + j));
        end
        @(negedge clk);
        tx_count = 12'(ntx); rx_count = 12'(nrx); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 idle and cs drop the cycle after start
        chk(idle == 1'b0 && cs_n == 1'b0, "R2", "idle/cs after start", {idle, cs_n}, 0);
    endtask

    task automatic wait_done(input string tag);
        while (idle !== 1'b1) @(negedge clk);
        // R8 cs already high when idle returns
        chk(cs_n == 1'b1, "R8", "cs high at idle", cs_n, 1);
        chk(exp_rx.size() == 0, tag, "rx bytes left", exp_rx.size(), 0);
        chk(exp_mosi.size() == 0, tag, "serial bytes left", exp_mosi.size(), 0);
        chk(src_q.size() == 0, "R4", "supplier bytes left", src_q.size(), 0);
    endtask

    task automatic set_div(input int d);
        half_div = 8'(d);
        eff_div = (d == 0) ? 1 : d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(idle && cs_n && !sclk && !tx_req && !rx_valid, "R11", "reset outputs",
            {idle, cs_n, sclk, tx_req, rx_valid}, 5'b11000);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        set_div(2);
        launch(1, 0, 1); wait_done("R3");
        launch(3, 4, 2); wait_done("R5");
        // back-to-back, exercises the gap (R7)
        launch(2, 2, 3); wait_done("R5");
        launch(0, 3, 4); wait_done("R6");

        set_div(0);
        launch(2, 1, 5); wait_done("R1");
        set_div(3);
        launch(1, 2, 6); wait_done("R1");

        // R9 both counts zero
        @(negedge clk);
        tx_count = '0; rx_count = '0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        begin
            bit ok9 = 1;
            for (int k = 0; k < 40; k++) begin
                if (!cs_n || !idle || sclk) ok9 = 0;
                @(negedge clk);
            end
            chk(ok9, "R9", "zero-count frame stayed idle", ok9, 1);
        end

        // R10 start while busy is ignored
        set_div(2);
        launch(1, 2, 7);
        repeat (20) @(negedge clk);
        tx_count = 12'd3; rx_count = 12'd3; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done("R10");
        repeat (30) @(negedge clk);
        chk(idle == 1'b1 && cs_n == 1'b1, "R10", "no second frame", {idle, cs_n}, 3);

        // R12 long receive run past 255 bytes
        set_div(1);
        launch(2, 300, 8); wait_done("R12");

        // R11 reset in mid-frame
        set_div(2);
        mon_off = 1'b1;
        launch(3, 3, 9);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(idle && cs_n && !sclk && !tx_req && !rx_valid, "R11", "mid-frame reset",
            {idle, cs_n, sclk, tx_req, rx_valid}, 5'b11000);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        src_q.delete(); exp_mosi.delete(); exp_rx.delete();
        mon_off = 1'b0;
        launch(1, 1, 10); wait_done("R11");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule